// File: doc/BRIEF.md
# Watchdog Timer With Register Port

This block is a watchdog timer for a system controller. Software sees two 32-bit registers through a simple register port. The control/status word sits at byte offset 0. The count word sits at byte offset 4.

Software programs a timeout in ticks into the count word. It then writes the control word to copy that value into the live counter and to start the timer. After that it must keep writing the reload bit before the counter runs out. The time base comes from a single-cycle tick enable input, which is nominally one pulse per second.

If the counter runs out, the block does three things. It latches a fired flag, it stops itself, and it raises a one-clock request on either the reset output or the shutdown output. Software picks which output by setting the action bit beforehand.

A strap input can disable the watchdog in hardware. While the strap is high, the run bit has no effect.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word reads as zero, apart from bit 3, which follows the strap. The count word reads 0. Both request outputs are low.
- R2: A write to offset 4 stores bits 15:0 of the data, and bits 31:16 of that word read back as 0. Offset 0 reads the control word. Every other offset reads 0, and a write to it changes nothing.
- R3: Control bit 0 is the run bit. Writing it as 1 starts the timer and writing it as 0 stops it. Starting the timer never loads the counter, so a counter left at 0 expires on the first tick.
- R4: Writing control bit 7 as 1 copies the stored count into the live counter. Bit 7 always reads back as 0.
- R5: While the timer runs, every tick lowers the counter by one. After a reload with N ≥ 1, expiry happens on the Nth tick. After a reload with 0, expiry happens on the first tick.
- R6: Expiry does three things on the clock edge of the expiring tick: it sets the fired flag (control bit 1), it clears the run bit, and it schedules a one-cycle request for the following cycle. The request goes to the shutdown output when control bit 2 is 1 and to the reset output when bit 2 is 0.
- R7: The fired flag is write-1-to-clear, so writing bit 1 as 0 leaves it unchanged. If an expiry happens in the same cycle as a clear, the flag ends up set.
- R8: While the strap input is high, control bit 3 reads 1. The run bit reads 0 and cannot be set. The counter holds its value and no expiry occurs.
- R9: Control bits 6:4 always read 0, and writing them has no effect.
- R10: A reload written in the same cycle as a tick takes priority. The counter loads the stored count, and no expiry happens in that cycle.
- R11: While the timer is stopped, ticks leave the counter unchanged. When the timer is started again, it continues from the value it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Time-base enable, one clock wide per tick |
| hw_disable | input | 1 | Hardware-disable strap |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rst_req | output | 1 | One-cycle request for a system reset |
| shut_req | output | 1 | One-cycle request for a system shutdown |

## Verification
The bench targets the edge cases listed below.

- **Zero count at start.** It starts the timer over a counter that still holds 0. A design that reloads on start would wait the full programmed count before expiring.
- **Reload of 0.** It reloads with 0. A design that decrements below zero would wrap around and never fire.
- **Reload on a tick cycle.** It writes the reload in the same cycle as a tick. A design that gives the tick priority would fire early or lose the reload.
- **Clear during expiry.** It clears the fired flag in the same cycle as an expiry. A design that gives the clear priority would hide the expiry.
- **Strap and stop/start.** It raises the strap while the timer runs, and it stops and restarts the timer. A design that ignores the strap would fire while disabled. A design that reloads on restart would shift the expiry cycle.

Random traffic is mixed in throughout: short counts, reserved-bit writes and writes to unmapped offsets. A bench model checks the read data and both request outputs on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_COUNT = 4;

  localparam int BIT_RUN    = 0;
  localparam int BIT_FIRED  = 1;
  localparam int BIT_ACTION = 2;
  localparam int BIT_DIS    = 3;
  localparam int BIT_RELOAD = 7;

  typedef enum logic {
    ACT_RESET    = 1'b0,
    ACT_SHUTDOWN = 1'b1
  } wd_action_e;

  typedef struct packed {
    logic       valid;
    logic       run;
    logic       fired_clr;
    wd_action_e action;
    logic       reload;
  } ctrl_cmd_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              st_run,
  input  logic              st_fired,
  input  wd_action_e        st_action,
  input  logic              st_dis,
  output ctrl_cmd_t         cmd,
  output logic [CNT_W-1:0]  count_val,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

  logic             sel_ctrl, sel_count;
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  assign sel_ctrl  = (addr == A_CTRL);
  assign sel_count = (addr == A_COUNT);

  // command decode for the control word
  always_comb begin
    cmd.valid     = wen & sel_ctrl;
    cmd.run       = wdata[BIT_RUN];
    cmd.fired_clr = wdata[BIT_FIRED];
    cmd.action    = wd_action_e'(wdata[BIT_ACTION]);
    cmd.reload    = wen & sel_ctrl & wdata[BIT_RELOAD];
  end

  assign count_en = wen & sel_count;
  assign count_d  = wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_val = count_q;

  // readback: reserved and reload bits are never driven
  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[BIT_RUN]    = st_run;
      rdata[BIT_FIRED]  = st_fired;
      rdata[BIT_ACTION] = st_action;
      rdata[BIT_DIS]    = st_dis;
    end else if (sel_count) begin
      rdata[CNT_W-1:0]  = count_q;
    end
  end

  wire unused_wdata = ^wdata;

  // R2: a count write lands in the stored count one cycle later
  p_count_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> count_q == $past(count_d));
  // R4 / R9: reload and reserved bits never appear on the control readback
  p_ctrl_rd_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |-> rdata[BIT_RELOAD:BIT_DIS+1] == '0);
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, at_end;

  assign step   = run & tick;
  assign at_end = (cnt_q <= ONE);
  assign expire = step & ~reload & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)                 cnt_d = load_val;
    else if (step && !at_end)   cnt_d = cnt_q - ONE;
    else if (step)              cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a reload always lands the stored count
  p_reload_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(load_val));
  // R11: stopped counter does not move
  p_stopped_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt_q));
  // R5: expiry only on a running tick
  p_expire_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> run && tick);
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_cmd_t  cmd,
  input  logic       expire,
  input  logic       hw_disable,
  output logic       run_eff,
  output logic       fired,
  output wd_action_e action,
  output logic       rst_pulse,
  output logic       shut_pulse
);
  logic       run_q, run_d;
  logic       fired_q, fired_d;
  wd_action_e act_q, act_d;
  logic       rst_q, rst_d, shut_q, shut_d;

  always_comb begin
    run_d = run_q;
    if (hw_disable)     run_d = 1'b0;
    else if (expire)    run_d = 1'b0;
    else if (cmd.valid) run_d = cmd.run;

    fired_d = fired_q;
    if (expire)                         fired_d = 1'b1;
    else if (cmd.valid && cmd.fired_clr) fired_d = 1'b0;

    act_d  = cmd.valid ? cmd.action : act_q;
    rst_d  = expire & (act_q == ACT_RESET);
    shut_d = expire & (act_q == ACT_SHUTDOWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      act_q   <= ACT_RESET;
      rst_q   <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      fired_q <= fired_d;
      act_q   <= act_d;
      rst_q   <= rst_d;
      shut_q  <= shut_d;
    end
  end

  assign run_eff    = run_q & ~hw_disable;
  assign fired      = fired_q;
  assign action     = act_q;
  assign rst_pulse  = rst_q;
  assign shut_pulse = shut_q;

  // R6: never both requests at once
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_q, shut_q}));
  // R6: requests last exactly one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q || shut_q) |=> !(rst_q || shut_q));
  // R6: a request comes with the flag set and the timer stopped
  p_fired_with_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q || shut_q) |-> fired_q && !run_q);
  // R7: a clear without expiry drops the flag
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.valid && cmd.fired_clr && !expire) |=> !fired_q);
  // R8: strap forces the run bit off
  p_strap_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_disable |=> !run_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 3,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              hw_disable,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rst_req,
  output logic              shut_req
);
  logic [SYNC_N-1:0] rs_q;
  logic              rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rs_q[SYNC_N-1];

  ctrl_cmd_t        cmd;
  logic [CNT_W-1:0] count_val;
  logic             run_eff, fired, expire;
  wd_action_e       action;

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .st_run(run_eff), .st_fired(fired),
    .st_action(action), .st_dis(hw_disable), .cmd(cmd),
    .count_val(count_val), .rdata(reg_rdata)
  );

  wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .run(run_eff), .tick(tick_en),
    .reload(cmd.reload), .load_val(count_val), .expire(expire)
  );

  wdog_ctl u_ctl (
    .clk(clk), .rst_n(rst_i_n), .cmd(cmd), .expire(expire),
    .hw_disable(hw_disable), .run_eff(run_eff), .fired(fired),
    .action(action), .rst_pulse(rst_req), .shut_pulse(shut_req)
  );
endmodule

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, hw_disable = 1'b0, reg_wen = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_req, shut_req;

  always #2 clk = ~clk;

  wdog_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .hw_disable(hw_disable), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req),
    .shut_req(shut_req));

  int total = 0, bad = 0;
  logic dis_req = 1'b0;
  logic m_run = 0, m_fired = 0, m_act = 0, e_rst = 0, e_shut = 0;
  logic [15:0] m_cnt = '0, m_ctr = '0;

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    if (a == 3'd0) return {28'd0, dis_req, m_act, m_fired, m_run & ~dis_req};
    if (a == 3'd4) return {16'd0, m_cnt};
    return 32'd0;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic tk, input logic has_x, input logic [31:0] x,
                      input string tag);
    logic cw, nw, rl, ex, adv;
    @(negedge clk);
    chk({31'd0, rst_req}, {31'd0, e_rst}, "R6 reset request");
    chk({31'd0, shut_req}, {31'd0, e_shut}, "R6 shutdown request");
    reg_wen = w; reg_addr = a; reg_wdata = d; tick_en = tk; hw_disable = dis_req;
    #1;
    if (!w) chk(reg_rdata, model_rd(a), "R2 readback");
    if (has_x) chk(reg_rdata, x, tag);
    cw  = w && a == 3'd0;
    nw  = w && a == 3'd4;
    rl  = cw && d[7];
    adv = m_run && !dis_req && tk;
    ex  = adv && !rl && (m_ctr <= 16'd1);
    @(posedge clk);
    e_rst  = ex && !m_act;
    e_shut = ex && m_act;
    if (rl) m_ctr = m_cnt;
    else if (adv) m_ctr = (m_ctr == 0) ? 16'd0 : m_ctr - 16'd1;
    if (dis_req || ex) m_run = 1'b0;
    else if (cw) m_run = d[0];
    if (ex) m_fired = 1'b1;
    else if (cw && d[1]) m_fired = 1'b0;
    if (cw) m_act = d[2];
    if (nw) m_cnt = d[15:0];
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 32'd0, "");
  endtask
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 1'b1, 1'b0, 32'd0, "");
  endtask
  task automatic peek(input logic [2:0] a, input logic [31:0] x, input string tag);
    step(1'b0, a, 32'd0, 1'b0, 1'b1, x, tag);
  endtask
  task automatic pulse_now(input logic r, input logic s, input string tag);
    #1;
    chk({30'd0, rst_req, shut_req}, {30'd0, r, s}, tag);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    chk({30'd0, rst_req, shut_req}, 32'd0, "R1 requests low");
    peek(3'd0, 32'd0, "R1 control after reset");
    peek(3'd4, 32'd0, "R1 count after reset");
    repeat (3) peek(3'd0, 32'd0, "R1 control idle");

    // R2: count width and unmapped offsets
    wr(3'd4, 32'h1234_abcd);
    peek(3'd4, 32'h0000_abcd, "R2 count low half");
    wr(3'd2, 32'hffff_ffff);
    peek(3'd2, 32'd0, "R2 unmapped read");
    peek(3'd0, 32'd0, "R2 unmapped write ignored");

    // R9: reserved bits
    wr(3'd0, 32'h0000_0074);
    peek(3'd0, 32'h0000_0004, "R9 reserved read 0");
    wr(3'd0, 32'd0);

    // R3: start does not reload; counter still 0
    wr(3'd4, 32'd5);
    wr(3'd0, 32'h1);
    peek(3'd0, 32'h1, "R3 run set");
    tick(1);
    pulse_now(1'b1, 1'b0, "R3 start without reload fires at once");
    peek(3'd0, 32'h2, "R6 fired set run clear");

    // R5: reload 3, expiry on the 3rd tick
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h83);
    peek(3'd0, 32'h1, "R7 fired cleared by W1C");
    tick(2);
    pulse_now(1'b0, 1'b0, "R5 no early expiry");
    tick(1);
    pulse_now(1'b1, 1'b0, "R5 expiry on third tick");

    // R5: reload with 0 fires on the first tick
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h83);
    tick(1);
    pulse_now(1'b1, 1'b0, "R5 zero count fires first tick");

    // R6: shutdown action
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h87);
    tick(1);
    pulse_now(1'b0, 1'b1, "R6 shutdown path");
    peek(3'd0, 32'h6, "R6 flag and action after expiry");

    // R7: write 0 keeps flag, write 1 clears
    wr(3'd0, 32'h4);
    peek(3'd0, 32'h4 | 32'h2, "R7 zero write keeps flag");
    wr(3'd0, 32'h2);
    peek(3'd0, 32'h0, "R7 one clears flag");

    // R7: clear in same cycle as expiry keeps flag set
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h81);
    step(1'b1, 3'd0, 32'h03, 1'b1, 1'b0, 32'd0, "");
    pulse_now(1'b1, 1'b0, "R7 expiry with clear");
    peek(3'd0, 32'h2, "R7 set wins over clear");

    // R10: reload on tick cycle wins
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h83);
    step(1'b1, 3'd0, 32'h81, 1'b1, 1'b0, 32'd0, "");
    pulse_now(1'b0, 1'b0, "R10 reload beats tick");
    tick(1);
    pulse_now(1'b1, 1'b0, "R10 expiry after reload");

    // R8: strap
    wr(3'd4, 32'd1);
    dis_req = 1'b1;
    wr(3'd0, 32'h83);
    peek(3'd0, 32'h8, "R8 strap shows, run blocked");
    tick(4);
    pulse_now(1'b0, 1'b0, "R8 no expiry while disabled");
    dis_req = 1'b0;
    peek(3'd0, 32'h0, "R8 run stays clear after strap");

    // R11: stop holds the count, restart continues
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h81);
    wr(3'd0, 32'h0);
    tick(6);
    pulse_now(1'b0, 1'b0, "R11 stopped ticks ignored");
    wr(3'd0, 32'h1);
    tick(1);
    pulse_now(1'b0, 1'b0, "R11 resumes at held count");
    tick(1);
    pulse_now(1'b1, 1'b0, "R11 expiry after resume");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 16;
      if (op < 3) begin
        r = $urandom & 32'hff;
        if (($urandom % 3) != 0) r[0] = 1'b1;
        wr(3'd0, r | ($urandom & 32'hffff_ff00));
      end else if (op < 5) begin
        r = (($urandom % 8) == 0) ? ($urandom % 300) : ($urandom % 6);
        wr(3'd4, r | ($urandom & 32'hffff_0000));
      end else if (op == 5) begin
        if (($urandom % 6) == 0) dis_req = ~dis_req;
        wr(3'($urandom % 8) | 3'd1, $urandom);
      end else begin
        logic [2:0] a;
        int sel;
        sel = $urandom % 3;
        a = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd4 : 3'($urandom % 8);
        step(1'b0, a, 32'd0, 1'($urandom % 2), 1'b0, 32'd0, "");
      end
    end
    dis_req = 1'b0;
    tick(2);
    finish_run();
  end
endmodule